// File: doc/BRIEF.md
# Byte-Coherent Timer Channel Value Register

This block is the 16-bit value register of one timer channel, reached from an 8-bit bus as a high byte and a low byte. In capture mode it holds the counter value taken at the last capture event. The first byte read takes a snapshot of both bytes, so that a two-access read never mixes halves from two different captures. In compare/PWM mode the bus writes the two bytes one at a time. They collect in a separate write buffer and move into the active register together, on a cycle where the timer logic signals that an update is allowed.

A control-register write strobe drops a pending read snapshot. A debug-halt input freezes the read pairing state. While halted, reads show the live register, so a debugger does not disturb a half-finished software read. The counter, the edge detection and the pin logic sit outside this block.

Top module: `chan_val_reg`

## Requirements
- R1: After reset, `chan_val_o` is 0, no read snapshot is held and no written byte is pending. Reads of either byte return 0.
- R2: In capture mode, when nothing is held, a read of either byte (`sel_hi_i`=1 selects bits 15:8, 0 selects bits 7:0) returns the live byte and snapshots all 16 bits. A later read of the opposite byte returns the snapshot byte, and that read releases the snapshot.
- R3: While a snapshot is held, rereading the byte that was read first returns the snapshot byte and does not release the snapshot.
- R4: A pulse on `ctrl_wr_i` releases a held snapshot, with or without debug halt. The next read then returns live data.
- R5: In capture mode, byte writes are discarded. They neither change `chan_val_o` nor count as a buffered byte.
- R6: While `dbg_halt_i` is high, reads return the live register bytes, and no read changes the snapshot state. A half-finished read resumes from the snapshot after the halt.
- R7: In compare mode, a single byte write leaves `chan_val_o` unchanged. Once both bytes are buffered, the 16-bit value loads into `chan_val_o` as one unit.
- R8: The load happens at the first clock edge after both bytes are buffered at which `upd_ok_i` is high. Until then, the pair stays buffered.
- R9: Writing the same byte twice before its partner replaces that byte in the buffer and does not complete the pair.
- R10: A capture event while a snapshot is held updates `chan_val_o` but not the snapshot.
- R11: In compare mode, reads return the bytes of `chan_val_o` and take no snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_mode_i | input | 1 | 1 = capture mode, 0 = compare/PWM mode |
| dbg_halt_i | input | 1 | Debug halt active |
| rd_en_i | input | 1 | Byte read strobe |
| wr_en_i | input | 1 | Byte write strobe |
| sel_hi_i | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid in the cycle of `rd_en_i` |
| ctrl_wr_i | input | 1 | Channel control register write strobe |
| cap_valid_i | input | 1 | Capture event strobe |
| cap_value_i | input | 16 | Counter value at the capture event |
| upd_ok_i | input | 1 | The buffered pair may load this cycle |
| chan_val_o | output | 16 | Active channel register |

## Verification
The assertions assume a bus that issues at most one byte access per cycle. They also assume that capture strobes arrive only in capture mode and that mode changes happen while no snapshot or pending pair could be confused between modes. The stimulus drives one strobe at a time from tasks at the falling clock edge. It changes `capture_mode_i` only between idle cycles, after the write pair is complete and after every snapshot has been released.

// File: rtl/chan_val_pkg.sv
package chan_val_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/chan_val_rd_coh.sv
module chan_val_rd_coh
  import chan_val_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int VAL_W = NUM_LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              halt_i,
  input  logic              rd_en_i,
  input  logic              sel_hi_i,
  input  logic              ctrl_wr_i,
  input  logic [VAL_W-1:0]  live_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic             held_q;
  byte_sel_e        first_q;
  logic [VAL_W-1:0] snap_q;
  logic             track;
  logic [VAL_W-1:0] src;

  // pairing only in capture mode and outside debug halt
  assign track = capture_i && !halt_i && rd_en_i && !ctrl_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      first_q <= SEL_LO;
      snap_q  <= '0;
    end else if (ctrl_wr_i) begin
      held_q <= 1'b0;
    end else if (track) begin
      if (!held_q) begin
        held_q  <= 1'b1;
        first_q <= byte_sel_e'(sel_hi_i);
        snap_q  <= live_i;
      end else if (byte_sel_e'(sel_hi_i) != first_q) begin
        held_q <= 1'b0;
      end
    end
  end

  assign src     = (capture_i && !halt_i && held_q) ? snap_q : live_i;
  assign rdata_o = sel_hi_i ? src[VAL_W-1:BYTE_W] : src[BYTE_W-1:0];

  AST_CTRL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> !held_q); // R4
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !ctrl_wr_i) |=> $stable(held_q)); // R6
  AST_SNAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |=> $stable(snap_q)); // R10
endmodule

// File: rtl/chan_val_wr_coh.sv
module chan_val_wr_coh
  import chan_val_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int VAL_W = NUM_LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              sel_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              upd_ok_i,
  output logic              xfer_o,
  output logic [VAL_W-1:0]  wbuf_o
);
  logic [NUM_LANES-1:0] got_q;
  logic [NUM_LANES-1:0] wr_bits;

  assign xfer_o  = (&got_q) && upd_ok_i;
  assign wr_bits = wr_en_i ? (sel_hi_i ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) got_q <= '0;
    else         got_q <= (xfer_o ? '0 : got_q) | wr_bits;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         wbuf_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_bits[g]) wbuf_o[g*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  AST_PAIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&got_q) && !upd_ok_i) |=> (&got_q)); // R8
  AST_ONE_LANE_PER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (got_q == 2'b00 && wr_en_i) |=> $countones(got_q) == 1); // R9
endmodule

// File: rtl/chan_val_reg.sv
module chan_val_reg
  import chan_val_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int VAL_W = NUM_LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_mode_i,
  input  logic              dbg_halt_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              sel_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              ctrl_wr_i,
  input  logic              cap_valid_i,
  input  logic [VAL_W-1:0]  cap_value_i,
  input  logic              upd_ok_i,
  output logic [VAL_W-1:0]  chan_val_o
);
  logic             xfer;
  logic [VAL_W-1:0] wbuf;

  chan_val_rd_coh #(.BYTE_W(BYTE_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_mode_i),
    .halt_i    (dbg_halt_i),
    .rd_en_i   (rd_en_i),
    .sel_hi_i  (sel_hi_i),
    .ctrl_wr_i (ctrl_wr_i),
    .live_i    (chan_val_o),
    .rdata_o   (rdata_o)
  );

  // writes discarded and loads held off in capture mode
  chan_val_wr_coh #(.BYTE_W(BYTE_W)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i && !capture_mode_i),
    .sel_hi_i (sel_hi_i),
    .wdata_i  (wdata_i),
    .upd_ok_i (upd_ok_i && !capture_mode_i),
    .xfer_o   (xfer),
    .wbuf_o   (wbuf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         chan_val_o <= '0;
    else if (capture_mode_i && cap_valid_i) chan_val_o <= cap_value_i;
    else if (!capture_mode_i && xfer)    chan_val_o <= wbuf;
  end

  AST_CAP_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_mode_i && !cap_valid_i) |=> $stable(chan_val_o)); // R5
  AST_LOAD_NEEDS_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_mode_i && !upd_ok_i) |=> $stable(chan_val_o)); // R8
  AST_CAPTURE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_mode_i && cap_valid_i) |=> chan_val_o == $past(cap_value_i)); // R10
endmodule

// File: tb/chan_val_reg_tb.sv
module chan_val_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        capture_mode_i = 1'b0;
  logic        dbg_halt_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        sel_hi_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        ctrl_wr_i = 1'b0;
  logic        cap_valid_i = 1'b0;
  logic [15:0] cap_value_i = '0;
  logic        upd_ok_i = 1'b0;
  logic [15:0] chan_val_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [15:0] VEC [4] = '{16'h1234, 16'hFFFF, 16'h00A5, 16'h8001};

  always #5 clk_i = ~clk_i;

  chan_val_reg u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic hi, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; sel_hi_i = hi;
    #2 d = rdata_o;
    @(posedge clk_i); #1 rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; sel_hi_i = hi; wdata_i = d;
    @(posedge clk_i); #1 wr_en_i = 1'b0;
  endtask

  task automatic upd();
    @(negedge clk_i); upd_ok_i = 1'b1;
    @(posedge clk_i); #1 upd_ok_i = 1'b0;
  endtask

  task automatic cap(input logic [15:0] v);
    @(negedge clk_i); cap_valid_i = 1'b1; cap_value_i = v;
    @(posedge clk_i); #1 cap_valid_i = 1'b0;
  endtask

  task automatic ctrl();
    @(negedge clk_i); ctrl_wr_i = 1'b1;
    @(posedge clk_i); #1 ctrl_wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] prev;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 value", chan_val_o, 16'h0);
    rd(1'b1, d); chk("R1 read hi", {8'h0, d}, 16'h0);
    rd(1'b0, d); chk("R1 read lo", {8'h0, d}, 16'h0);

    // R7 R11 vector table: pair load and compare-mode reads
    prev = 16'h0;
    foreach (VEC[i]) begin
      wr(1'b1, VEC[i][15:8]);
      idle(1); chk("R7 half write no load", chan_val_o, prev);
      wr(1'b0, VEC[i][7:0]);
      idle(1); chk("R7 pair waits", chan_val_o, prev);
      upd(); idle(0);
      chk("R7 pair loaded", chan_val_o, VEC[i]);
      rd(1'b1, d); chk("R11 read hi", {8'h0, d}, {8'h0, VEC[i][15:8]});
      rd(1'b0, d); chk("R11 read lo", {8'h0, d}, {8'h0, VEC[i][7:0]});
      rd(1'b0, d); chk("R11 no snapshot", {8'h0, d}, {8'h0, VEC[i][7:0]});
      prev = VEC[i];
    end

    // R8 load held until upd_ok_i
    wr(1'b0, 8'h34); wr(1'b1, 8'h12);
    idle(3); chk("R8 held", chan_val_o, 16'h8001);
    upd(); idle(0); chk("R8 loaded", chan_val_o, 16'h1234);

    // R9 same byte twice
    wr(1'b0, 8'hAA); wr(1'b0, 8'hBB);
    upd(); idle(0); chk("R9 no pair", chan_val_o, 16'h1234);
    wr(1'b1, 8'hCC);
    upd(); idle(0); chk("R9 latest byte", chan_val_o, 16'hCCBB);

    // R5 capture-mode writes discarded
    capture_mode_i = 1'b1;
    cap(16'hA1B2); idle(0);
    wr(1'b1, 8'hFF); upd(); wr(1'b0, 8'hEE); upd(); idle(0);
    chk("R5 write dropped", chan_val_o, 16'hA1B2);

    // R2 R10 snapshot
    rd(1'b1, d); chk("R2 first hi live", {8'h0, d}, 16'h00A1);
    cap(16'h1111); idle(0);
    chk("R10 live updates", chan_val_o, 16'h1111);
    rd(1'b0, d); chk("R2 R10 lo from snapshot", {8'h0, d}, 16'h00B2);
    rd(1'b0, d); chk("R2 released, lo live", {8'h0, d}, 16'h0011);
    rd(1'b1, d); chk("R2 hi partner", {8'h0, d}, 16'h0011);

    // R3 reread first byte keeps snapshot
    cap(16'h2233);
    rd(1'b1, d); chk("R3 first", {8'h0, d}, 16'h0022);
    cap(16'h4455);
    rd(1'b1, d); chk("R3 reread hi", {8'h0, d}, 16'h0022);
    rd(1'b0, d); chk("R3 still held", {8'h0, d}, 16'h0033);
    rd(1'b1, d); chk("R3 after release", {8'h0, d}, 16'h0044);
    rd(1'b0, d); chk("R3 new pair lo", {8'h0, d}, 16'h0055);

    // R4 control write releases
    cap(16'h6677);
    rd(1'b1, d); chk("R4 first", {8'h0, d}, 16'h0066);
    cap(16'h8899);
    ctrl();
    rd(1'b0, d); chk("R4 released", {8'h0, d}, 16'h0099);
    rd(1'b1, d); chk("R4 partner", {8'h0, d}, 16'h0088);

    // R6 debug halt
    cap(16'h1357);
    rd(1'b1, d); chk("R6 first", {8'h0, d}, 16'h0013);
    cap(16'h2468);
    dbg_halt_i = 1'b1;
    rd(1'b0, d); chk("R6 halt lo live", {8'h0, d}, 16'h0068);
    rd(1'b1, d); chk("R6 halt hi live", {8'h0, d}, 16'h0024);
    dbg_halt_i = 1'b0;
    rd(1'b0, d); chk("R6 resume snapshot", {8'h0, d}, 16'h0057);
    rd(1'b1, d); chk("R6 released", {8'h0, d}, 16'h0024);
    rd(1'b0, d); chk("R6 partner", {8'h0, d}, 16'h0068);

    // R4 release during halt
    cap(16'hABCD);
    rd(1'b1, d); chk("R4 halt first", {8'h0, d}, 16'h00AB);
    cap(16'hEF01);
    dbg_halt_i = 1'b1;
    ctrl();
    dbg_halt_i = 1'b0;
    rd(1'b0, d); chk("R4 halt released", {8'h0, d}, 16'h0001);
    rd(1'b1, d); chk("R4 halt partner", {8'h0, d}, 16'h00EF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule